// File: doc/BRIEF.md
# Command-Indexed Bank Mapper

This block extends the address space of an 8-bit processor and its pattern fetch unit. Software writes a command byte first. Its low nibble picks one of the bank registers. A second write then carries the bank number for that register. The block keeps four 8 KB program bank numbers and eight 1 KB pattern bank numbers. From these it turns a CPU address in the upper 32 KB, and a 13-bit pattern address, into a bank-extended address.

Two bits of the command byte rearrange the maps. One bit exchanges the first and third program windows. The other bit exchanges the two 4 KB halves of pattern space. A separate register picks one of four nametable mirroring modes. Both lookups are combinational and read the current register contents, so a register write is seen by lookups from the clock edge that takes it.

The CPU write port is a plain strobe. A write is always taken in the cycle its strobe is high, and the port exerts no back-pressure. The lookup ports have no handshake: the outputs follow the inputs in the same cycle. The parameter `PRG_BANKS` (a power of two, at least 2) sets the program bank count. The parameter `CHR_RAM` selects whether pattern memory is a small 8 KB RAM.

Top module: `cbm_mapper`

## Requirements
- R1: With `cpu_we` high, an even `cpu_addr` whose bits 15:13 are 100 loads the command byte from `cpu_data`. Address bits 12:1 are not decoded.
- R2: An odd address with bits 15:13 = 100 is a data write, aimed by command bits 3:0. Index 0 sets pattern slot 0 to D and slot 1 to D+1 (modulo 256). Index 1 does the same for slots 2 and 3.
- R3: Command indices 2, 3, 4 and 5 load pattern slots 4, 5, 6 and 7 respectively.
- R4: Command indices 6, 7, 8 and 9 load program slots 0, 1, 2 and 3 respectively.
- R5: Index 0xA loads pattern slot 1 alone, and index 0xB loads pattern slot 3 alone. The neighbouring even slot is left unchanged.
- R6: A data write with index 0xC to 0xF changes no bank register.
- R7: `prg_addr[14:13]` picks a CPU window. With command bit 6 clear, windows 0..3 use program slots 0,1,2,3. With bit 6 set, they use slots 2,1,0,3. `prg_ext_addr` = {bank, `prg_addr[12:0]`}.
- R8: `chr_addr[12:10]` picks a 1 KB slot. This slot index is XORed with 4 when command bit 7 is set. `chr_ext_addr` = {8-bit bank, `chr_addr[9:0]`}.
- R9: After reset the program slots hold 0, 1, `PRG_BANKS`-2 and `PRG_BANKS`-1. Pattern slot n holds n, the command byte is 0, and the mirroring mode is 0.
- R10: An even address with bits 15:13 = 101 sets `mirror_mode` from `cpu_data[1:0]`. The codes are 0 vertical, 1 horizontal, 2 one-screen low and 3 one-screen high.
- R11: With `CHR_RAM`=1, every pattern bank number is reduced to its low 3 bits on output.
- R12: Program bank numbers are output modulo `PRG_BANKS`.
- R13: A write with `cpu_we` low, to an odd address with bits 15:13 = 101, or to any other region changes no register and no lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| prg_addr | input | 15 | CPU address offset within 0x8000-0xFFFF |
| prg_ext_addr | output | $clog2(PRG_BANKS)+13 | Bank-extended program address |
| chr_addr | input | 13 | Pattern address 0x0000-0x1FFF |
| chr_ext_addr | output | 18 | Bank-extended pattern address |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The hardest state to reach is one where both swap bits are set and slot values from the paired loads sit next to values loaded one by one through indices 0xA and 0xB. A lookup must then pick the correct rearranged slot. Directed writes cover each command index, including a data byte of 0xFF to make the pair increment wrap. A long seeded random run then mixes command bytes that carry random swap bits with data writes, mirroring writes and undecoded writes. After each batch every program window and pattern slot is read back on both a ROM-style and a RAM-style instance.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef logic [7:0] bank_t;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam int NUM_PRG_SLOTS = 4;
  localparam int NUM_CHR_SLOTS = 8;
  localparam int CHR_OFS_W     = 10;
  localparam int PRG_OFS_W     = 13;
endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [2:0]                    addr_hi,
  input  logic                          addr_lsb,
  input  logic [7:0]                    data,
  output bank_t [NUM_PRG_SLOTS-1:0]     prg_q,
  output bank_t [NUM_CHR_SLOTS-1:0]     chr_q,
  output logic                          prg_swap,
  output logic                          chr_flip,
  output mirror_e                       mirror_q
);
  localparam bank_t PRG_LAST = bank_t'(PRG_BANKS - 1);
  localparam bank_t PRG_PREV = bank_t'(PRG_BANKS - 2);

  logic [7:0] cmd_q;
  logic       sel_bank, cmd_wr, dat_wr, mir_wr;
  logic [3:0] idx;

  assign sel_bank = we && (addr_hi == 3'b100);
  assign cmd_wr   = sel_bank && !addr_lsb;
  assign dat_wr   = sel_bank && addr_lsb;
  assign mir_wr   = we && (addr_hi == 3'b101) && !addr_lsb;
  assign idx      = cmd_q[3:0];
  assign prg_swap = cmd_q[6];
  assign chr_flip = cmd_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= 8'h00;
      mirror_q <= MIR_VERT;
      prg_q[0] <= 8'd0;
      prg_q[1] <= 8'd1;
      prg_q[2] <= PRG_PREV;
      prg_q[3] <= PRG_LAST;
      for (int i = 0; i < NUM_CHR_SLOTS; i++) chr_q[i] <= bank_t'(i);
    end else begin
      if (cmd_wr) cmd_q <= data;
      if (mir_wr) mirror_q <= mirror_e'(data[1:0]);
      if (dat_wr) begin
        case (idx)
          4'h0: begin chr_q[0] <= data; chr_q[1] <= data + 8'd1; end
          4'h1: begin chr_q[2] <= data; chr_q[3] <= data + 8'd1; end
          4'h2: chr_q[4] <= data;
          4'h3: chr_q[5] <= data;
          4'h4: chr_q[6] <= data;
          4'h5: chr_q[7] <= data;
          4'h6: prg_q[0] <= data;
          4'h7: prg_q[1] <= data;
          4'h8: prg_q[2] <= data;
          4'h9: prg_q[3] <= data;
          4'hA: chr_q[1] <= data;
          4'hB: chr_q[3] <= data;
          default: ;
        endcase
      end
    end
  end

  assert_cmd_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_q == $past(data)));

  assert_pair_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == 4'h0) |=> (chr_q[1] == chr_q[0] + 8'd1));

  assert_prg_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == 4'h9) |=> (prg_q[3] == $past(data)));

  assert_odd_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == 4'hA) |=> $stable(chr_q[0]));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx >= 4'hC) |=> ($stable(prg_q) && $stable(chr_q)));
endmodule

// File: rtl/cbm_prg_xlate.sv
module cbm_prg_xlate
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  bank_t [NUM_PRG_SLOTS-1:0]      prg_q,
  input  logic                           swap,
  input  logic [14:0]                    addr,
  output logic [$clog2(PRG_BANKS)+PRG_OFS_W-1:0] ext_addr
);
  localparam int BANK_W = $clog2(PRG_BANKS);

  logic [1:0] window;
  bank_t      bank_sel;

  assign window = addr[14:13];

  always_comb begin
    case (window)
      2'd0:    bank_sel = swap ? prg_q[2] : prg_q[0];
      2'd1:    bank_sel = prg_q[1];
      2'd2:    bank_sel = swap ? prg_q[0] : prg_q[2];
      default: bank_sel = prg_q[3];
    endcase
  end

  assign ext_addr = {bank_sel[BANK_W-1:0], addr[PRG_OFS_W-1:0]};

  generate
    if (BANK_W < 8) begin : g_drop_hi
      logic unused_bank_hi;
      assign unused_bank_hi = ^bank_sel[7:BANK_W];
    end
  endgenerate
endmodule

// File: rtl/cbm_chr_xlate.sv
module cbm_chr_xlate
  import cbm_pkg::*;
#(
  parameter bit CHR_RAM = 1'b0
) (
  input  bank_t [NUM_CHR_SLOTS-1:0] chr_q,
  input  logic                      flip,
  input  logic [12:0]               addr,
  output logic [17:0]               ext_addr
);
  logic [2:0] slot;
  bank_t      bank_raw, bank_out;

  assign slot     = addr[12:10] ^ {flip, 2'b00};
  assign bank_raw = chr_q[slot];

  generate
    if (CHR_RAM) begin : g_ram
      assign bank_out = {5'b00000, bank_raw[2:0]};
      logic unused_ram_hi;
      assign unused_ram_hi = ^bank_raw[7:3];
    end else begin : g_rom
      assign bank_out = bank_raw;
    end
  endgenerate

  assign ext_addr = {bank_out, addr[CHR_OFS_W-1:0]};
endmodule

// File: rtl/cbm_mapper.sv
module cbm_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter bit CHR_RAM   = 1'b0
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cpu_we,
  input  logic [15:0]                              cpu_addr,
  input  logic [7:0]                               cpu_data,
  input  logic [14:0]                              prg_addr,
  output logic [$clog2(PRG_BANKS)+PRG_OFS_W-1:0]   prg_ext_addr,
  input  logic [12:0]                              chr_addr,
  output logic [17:0]                              chr_ext_addr,
  output logic [1:0]                               mirror_mode
);
  localparam int PRG_BANK_W = $clog2(PRG_BANKS);
  localparam int PRG_EXT_W  = PRG_BANK_W + PRG_OFS_W;

  bank_t [NUM_PRG_SLOTS-1:0] prg_q;
  bank_t [NUM_CHR_SLOTS-1:0] chr_q;
  logic                      prg_swap, chr_flip;
  mirror_e                   mirror_q;
  logic                      unused_addr_mid;

  assign unused_addr_mid = ^cpu_addr[12:1];

  cbm_regfile #(.PRG_BANKS(PRG_BANKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cpu_we),
    .addr_hi  (cpu_addr[15:13]),
    .addr_lsb (cpu_addr[0]),
    .data     (cpu_data),
    .prg_q    (prg_q),
    .chr_q    (chr_q),
    .prg_swap (prg_swap),
    .chr_flip (chr_flip),
    .mirror_q (mirror_q)
  );

  cbm_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .prg_q    (prg_q),
    .swap     (prg_swap),
    .addr     (prg_addr),
    .ext_addr (prg_ext_addr)
  );

  cbm_chr_xlate #(.CHR_RAM(CHR_RAM)) u_chr (
    .chr_q    (chr_q),
    .flip     (chr_flip),
    .addr     (chr_addr),
    .ext_addr (chr_ext_addr)
  );

  assign mirror_mode = mirror_q;

  assert_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b101 && !cpu_addr[0])
      |=> (mirror_mode == $past(cpu_data[1:0])));

  assert_swap_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_swap && prg_addr[14:13] == 2'b00)
      |-> (prg_ext_addr[PRG_EXT_W-1:PRG_OFS_W] == prg_q[2][PRG_BANK_W-1:0]));

  assert_flip_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_flip && chr_addr[12:10] == 3'd0 && !CHR_RAM)
      |-> (chr_ext_addr[17:10] == chr_q[4]));

  assert_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> ($stable(prg_addr) -> $stable(prg_ext_addr)));
endmodule

// File: tb/test_cbm_mapper.sv
`timescale 1ns/1ps
module test_cbm_mapper;
  localparam int PRG_BANKS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_data = 8'h0;
  logic [14:0] prg_addr = 15'h0;
  logic [12:0] chr_addr = 13'h0;
  logic [17:0] prg_ext_a, prg_ext_b, chr_ext_a, chr_ext_b;
  logic [1:0]  mir_a, mir_b;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_cmd;
  logic [7:0] m_prg [4];
  logic [7:0] m_chr [8];
  logic [1:0] m_mir;

  always #2.5 clk = ~clk;

  cbm_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_RAM(1'b0)) i_cbm_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .prg_addr(prg_addr), .prg_ext_addr(prg_ext_a),
    .chr_addr(chr_addr), .chr_ext_addr(chr_ext_a), .mirror_mode(mir_a));

  cbm_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_RAM(1'b1)) i_cbm_mapper_ram (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .prg_addr(prg_addr), .prg_ext_addr(prg_ext_b),
    .chr_addr(chr_addr), .chr_ext_addr(chr_ext_b), .mirror_mode(mir_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cmd = 8'h00;
    m_mir = 2'd0;
    m_prg[0] = 8'd0;
    m_prg[1] = 8'd1;
    m_prg[2] = 8'(PRG_BANKS - 2);
    m_prg[3] = 8'(PRG_BANKS - 1);
    for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (a[15:13] == 3'b100 && !a[0]) m_cmd = d;
    else if (a[15:13] == 3'b100) begin
      case (m_cmd[3:0])
        4'h0: begin m_chr[0] = d; m_chr[1] = d + 8'd1; end
        4'h1: begin m_chr[2] = d; m_chr[3] = d + 8'd1; end
        4'h2: m_chr[4] = d;
        4'h3: m_chr[5] = d;
        4'h4: m_chr[6] = d;
        4'h5: m_chr[7] = d;
        4'h6: m_prg[0] = d;
        4'h7: m_prg[1] = d;
        4'h8: m_prg[2] = d;
        4'h9: m_prg[3] = d;
        4'hA: m_chr[1] = d;
        4'hB: m_chr[3] = d;
        default: ;
      endcase
    end else if (a[15:13] == 3'b101 && !a[0]) m_mir = d[1:0];
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, bit strobe = 1'b1);
    @(negedge clk);
    cpu_we = strobe; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_we = 1'b0;
    if (strobe) model_write(a, d);
  endtask

  function automatic logic [17:0] exp_prg(logic [14:0] a);
    logic [7:0] b;
    case (a[14:13])
      2'd0: b = m_cmd[6] ? m_prg[2] : m_prg[0];
      2'd1: b = m_prg[1];
      2'd2: b = m_cmd[6] ? m_prg[0] : m_prg[2];
      default: b = m_prg[3];
    endcase
    b = b & 8'(PRG_BANKS - 1);
    return {b[4:0], a[12:0]};
  endfunction

  function automatic logic [17:0] exp_chr(logic [12:0] a, bit ram);
    logic [2:0] s;
    logic [7:0] b;
    s = a[12:10] ^ {m_cmd[7], 2'b00};
    b = m_chr[s];
    if (ram) b = b & 8'h07;
    return {b, a[9:0]};
  endfunction

  task automatic check_map(string req);
    for (int w = 0; w < 4; w++) begin
      prg_addr = {w[1:0], 13'($urandom)};
      #0.4;
      chk({req, " prg window"}, 32'(prg_ext_a), 32'(exp_prg(prg_addr)));
    end
    for (int s = 0; s < 8; s++) begin
      chr_addr = {s[2:0], 10'($urandom)};
      #0.4;
      chk({req, " chr slot"}, 32'(chr_ext_a), 32'(exp_chr(chr_addr, 1'b0)));
      chk({req, " R11 chr ram"}, 32'(chr_ext_b), 32'(exp_chr(chr_addr, 1'b1)));
    end
    chk({req, " R10 mirror"}, 32'(mir_a), 32'(m_mir));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_map("R9 reset");

    // R1 command at an even address with unused middle bits set; R2 pair wrap
    wr(16'h9F02, 8'h00); wr(16'h8001, 8'hFF);
    wr(16'h8000, 8'h01); wr(16'h9FFF, 8'h40);
    check_map("R1 R2 pair");
    for (int i = 2; i <= 5; i++) begin
      wr(16'h8000, 8'(i)); wr(16'h8001, 8'(8'h10 + i));
    end
    check_map("R3 single slots");
    for (int i = 6; i <= 9; i++) begin
      wr(16'h8000, 8'(i)); wr(16'h8001, 8'(8'hE0 + i));
    end
    check_map("R4 R12 prg masked");
    wr(16'h8000, 8'h0A); wr(16'h8001, 8'h77);
    wr(16'h8000, 8'h0B); wr(16'h8001, 8'h88);
    check_map("R5 odd alone");
    for (int i = 12; i <= 15; i++) begin
      wr(16'h8000, 8'(i)); wr(16'h8001, 8'h55);
    end
    check_map("R6 ignored index");
    wr(16'h8000, 8'h40); check_map("R7 swap");
    wr(16'h8000, 8'h80); check_map("R8 flip");
    wr(16'h8000, 8'hC0); check_map("R7 R8 both");
    for (int c = 0; c < 4; c++) begin
      wr(16'hA000, 8'(8'hFC | c));
      chk("R10 mirror code", 32'(mir_a), 32'(c));
    end
    wr(16'hA001, 8'h01);
    chk("R13 odd mirror addr", 32'(mir_a), 32'(m_mir));
    wr(16'h8000, 8'h06, 1'b0);
    wr(16'h8001, 8'h1F, 1'b0);
    wr(16'hC000, 8'h06); wr(16'h6001, 8'h33); wr(16'hE001, 8'h07);
    check_map("R13 undecoded");

    for (int n = 0; n < 600; n++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom % 8);
      case (k)
        0, 1: a = 16'h8000 | (16'($urandom) & 16'h1FFE);
        2, 3, 4: a = 16'h8001 | (16'($urandom) & 16'h1FFE);
        5: a = 16'hA000 | (16'($urandom) & 16'h1FFE);
        6: a = (16'($urandom) & 16'h7FFF) | 16'hA001;
        default: a = 16'($urandom);
      endcase
      wr(a, 8'($urandom), k != 7);
      if (n % 12 == 11) check_map("R7 R8 random");
    end

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check_map("R9 second reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule